// File: doc/BRIEF.md
# Dual-Clock FIFO with Status Flags

This block is a first-in first-out buffer whose write side and read side run on unrelated clocks. A producer pushes words with a write enable on its own clock. A consumer pulls words with a read enable on a second clock. Each side sees only the flags that are computed in its own domain: full and almost-full on the write side, empty and almost-empty on the read side. Each side also has a registered error flag that reports a refused access: a write while full, or a read while empty.

The write and read pointers are one bit wider than the address, so that a completely full buffer can be told apart from an empty one. Each pointer is converted to Gray code and passes through a two-flop synchronizer into the other domain. The flags are therefore pessimistic. A flag that blocks an access asserts at once, but it clears only after the other side's pointer has crossed over.

One asynchronous reset input serves both domains. Each domain has its own synchronizer, so reset asserts at once and is released on that domain's clock. Two parameters set how far from full and from empty the two warning flags switch.

Top module: `dual_clock_fifo`

## Requirements
- R1: While reset is high, and after it is released until the first write, full, almost_full, wr_err and rd_err are 0, and empty and almost_empty are 1. After release, rd_data is 0.
- R2: Words accepted on the write side leave on the read side in the same order, with none lost and none repeated, while the two clocks run at different rates.
- R3: A write on a write-clock edge where full is 1 is ignored: the word is never stored and is never delivered on rd_data.
- R4: After each write-clock edge, wr_err equals (wr_en AND full) as sampled at that edge.
- R5: A read on a read-clock edge where empty is 1 leaves rd_data unchanged. The last word delivered stays on the output.
- R6: After each read-clock edge, rd_err equals (rd_en AND empty) as sampled at that edge. It stays 1 for as long as both stay 1, and it returns to 0 on the first edge after rd_en falls.
- R7: full rises on the write edge that stores the 2**ADDR_W-th unread word, and it clears once reads have been seen on the write side. The write-side fill level never exceeds 2**ADDR_W.
- R8: almost_full is 1 exactly when the write-side fill level is at least 2**ADDR_W minus AF_OFFSET. With no reads in flight, this is the case after 14 stored words at the defaults (depth 16, offset 2).
- R9: empty falls only when the read side holds at least one word. It rises on the read edge that delivers the last stored word.
- R10: almost_empty is 1 exactly when the read-side fill level is at most AE_OFFSET (default 2).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst | input | 1 | Asynchronous reset, active high; hold for at least three cycles of each clock |
| wr_clk | input | 1 | Write-side clock |
| wr_en | input | 1 | Write request |
| wr_data | input | DATA_W | Word to store |
| full | output | 1 | No room left (write domain) |
| almost_full | output | 1 | Fill level at or above depth minus AF_OFFSET |
| wr_err | output | 1 | Previous write edge saw a write while full |
| rd_clk | input | 1 | Read-side clock |
| rd_en | input | 1 | Read request |
| rd_data | output | DATA_W | Last word read; updated only by accepted reads |
| empty | output | 1 | Nothing to read (read domain) |
| almost_empty | output | 1 | Fill level at or below AE_OFFSET |
| rd_err | output | 1 | Previous read edge saw a read while empty |

## Verification
The assertions check several properties on every edge of the clock that owns them. A write or read while blocked never moves a pointer and never changes rd_data. Both error flags follow their enable-and-flag condition one edge later. The write-side fill level stays within the depth. A Gray pointer changes by at most one bit per edge. A clear empty flag always means the read side holds data. Some behaviour only the bench scenarios can show: end-to-end data order across two unrelated clocks, the exact fill counts at which full, almost-full, empty and almost-empty switch, and that a refused word never shows up on the output.

// File: rtl/dcf_pkg.sv
`timescale 1ns/1ps
package dcf_pkg;
  localparam int CW = 32;
  typedef logic [CW-1:0] word_t;

  // binary to reflected Gray code
  function automatic word_t gray_of(word_t b);
    return b ^ (b >> 1);
  endfunction

  // reflected Gray code back to binary
  function automatic word_t bin_of(word_t g);
    word_t b;
    b[CW-1] = g[CW-1];
    for (int i = CW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  // distance from tail to head on a ring of 2**pw positions
  function automatic word_t ring_level(word_t head, word_t tail, int unsigned pw);
    word_t mask;
    mask = (word_t'(1) << pw) - word_t'(1);
    return (head - tail) & mask;
  endfunction
endpackage

// File: rtl/dcf_rst_sync.sv
`timescale 1ns/1ps
module dcf_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst,
  output logic srst
);
  logic [STAGES-1:0] chain;

  // assert at once, release after STAGES clean edges
  always_ff @(posedge clk or posedge arst) begin
    if (arst) chain <= '1;
    else      chain <= {chain[STAGES-2:0], 1'b0};
  end

  assign srst = chain[STAGES-1];
endmodule

// File: rtl/dcf_gray_sync.sv
`timescale 1ns/1ps
module dcf_gray_sync #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         srst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or posedge srst) begin
    if (srst) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/dcf_wr_side.sv
`timescale 1ns/1ps
module dcf_wr_side
  import dcf_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int AF_OFFSET = 2
) (
  input  logic              clk,
  input  logic              srst,
  input  logic              wr_en,
  input  logic [ADDR_W:0]   rq_gray,
  output logic              full,
  output logic              afull,
  output logic              wr_err,
  output logic [ADDR_W:0]   wgray,
  output logic [ADDR_W-1:0] waddr,
  output logic              wr_go
);
  localparam int PW    = ADDR_W + 1;
  localparam int DEPTH = 1 << ADDR_W;
  localparam logic [PW-1:0] FULL_LVL = PW'(DEPTH);
  localparam logic [PW-1:0] AF_LVL   = PW'(DEPTH - AF_OFFSET);

  logic [PW-1:0] wbin, wbin_nx, rq_bin, lvl_nx, lvl_now;

  // named internal events
  assign wr_go   = wr_en && !full;
  assign wbin_nx = wbin + PW'(wr_go);
  assign rq_bin  = PW'(bin_of(word_t'(rq_gray)));
  assign lvl_nx  = PW'(ring_level(word_t'(wbin_nx), word_t'(rq_bin), PW));
  assign lvl_now = PW'(ring_level(word_t'(wbin), word_t'(rq_bin), PW));
  assign waddr   = wbin[ADDR_W-1:0];

  always_ff @(posedge clk or posedge srst) begin
    if (srst) begin
      wbin   <= '0;
      wgray  <= '0;
      full   <= 1'b0;
      afull  <= 1'b0;
      wr_err <= 1'b0;
    end else begin
      wbin   <= wbin_nx;
      wgray  <= PW'(gray_of(word_t'(wbin_nx)));
      full   <= (lvl_nx == FULL_LVL);
      afull  <= (lvl_nx >= AF_LVL);
      wr_err <= wr_en && full;
    end
  end

  assert_reset_flags_R1: assert property (@(posedge clk)
    srst |-> (!full && !afull && !wr_err));
  assert_gray_step_R2: assert property (@(posedge clk) disable iff (srst)
    $onehot0(wgray ^ $past(wgray)));
  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (srst)
    (wr_en && full) |=> (wbin == $past(wbin)));
  assert_wr_err_set_R4: assert property (@(posedge clk) disable iff (srst)
    (wr_en && full) |=> wr_err);
  assert_wr_err_clr_R4: assert property (@(posedge clk) disable iff (srst)
    !(wr_en && full) |=> !wr_err);
  assert_level_cap_R7: assert property (@(posedge clk) disable iff (srst)
    lvl_now <= FULL_LVL);
endmodule

// File: rtl/dcf_rd_side.sv
`timescale 1ns/1ps
module dcf_rd_side
  import dcf_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int DATA_W    = 8,
  parameter int AE_OFFSET = 2
) (
  input  logic              clk,
  input  logic              srst,
  input  logic              rd_en,
  input  logic [ADDR_W:0]   wq_gray,
  input  logic [DATA_W-1:0] mem_q,
  output logic              empty,
  output logic              aempty,
  output logic              rd_err,
  output logic [ADDR_W:0]   rgray,
  output logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rd_data
);
  localparam int PW = ADDR_W + 1;
  localparam logic [PW-1:0] AE_LVL = PW'(AE_OFFSET);

  logic          rd_go;
  logic [PW-1:0] rbin, rbin_nx, wq_bin, lvl_nx;

  assign rd_go   = rd_en && !empty;
  assign rbin_nx = rbin + PW'(rd_go);
  assign wq_bin  = PW'(bin_of(word_t'(wq_gray)));
  assign lvl_nx  = PW'(ring_level(word_t'(wq_bin), word_t'(rbin_nx), PW));
  assign raddr   = rbin[ADDR_W-1:0];

  always_ff @(posedge clk or posedge srst) begin
    if (srst) begin
      rbin    <= '0;
      rgray   <= '0;
      empty   <= 1'b1;
      aempty  <= 1'b1;
      rd_err  <= 1'b0;
      rd_data <= '0;
    end else begin
      rbin   <= rbin_nx;
      rgray  <= PW'(gray_of(word_t'(rbin_nx)));
      empty  <= (lvl_nx == '0);
      aempty <= (lvl_nx <= AE_LVL);
      rd_err <= rd_en && empty;
      if (rd_go) rd_data <= mem_q;
    end
  end

  assert_reset_flags_R1: assert property (@(posedge clk)
    srst |-> (empty && aempty && !rd_err));
  assert_gray_step_R2: assert property (@(posedge clk) disable iff (srst)
    $onehot0(rgray ^ $past(rgray)));
  assert_hold_on_empty_R5: assert property (@(posedge clk) disable iff (srst)
    (rd_en && empty) |=> ($stable(rd_data) && (rbin == $past(rbin))));
  assert_rd_err_set_R6: assert property (@(posedge clk) disable iff (srst)
    (rd_en && empty) |=> rd_err);
  assert_rd_err_clr_R6: assert property (@(posedge clk) disable iff (srst)
    !(rd_en && empty) |=> !rd_err);
  assert_no_underflow_R9: assert property (@(posedge clk) disable iff (srst)
    !empty |-> (wq_bin != rbin));
endmodule

// File: rtl/dual_clock_fifo.sv
`timescale 1ns/1ps
module dual_clock_fifo #(
  parameter int DATA_W    = 8,
  parameter int ADDR_W    = 4,
  parameter int AF_OFFSET = 2,
  parameter int AE_OFFSET = 2
) (
  input  logic              rst,
  input  logic              wr_clk,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic              full,
  output logic              almost_full,
  output logic              wr_err,
  input  logic              rd_clk,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              empty,
  output logic              almost_empty,
  output logic              rd_err
);
  localparam int PW    = ADDR_W + 1;
  localparam int DEPTH = 1 << ADDR_W;

  logic              wr_srst, rd_srst, wr_go;
  logic [PW-1:0]     wgray, rgray, wgray_rs, rgray_ws;
  logic [ADDR_W-1:0] waddr, raddr;
  logic [DATA_W-1:0] mem_q;
  logic [DATA_W-1:0] store [DEPTH];

  dcf_rst_sync #(.STAGES(2)) u_wr_rst (.clk(wr_clk), .arst(rst), .srst(wr_srst));
  dcf_rst_sync #(.STAGES(2)) u_rd_rst (.clk(rd_clk), .arst(rst), .srst(rd_srst));

  dcf_gray_sync #(.W(PW)) u_r2w (.clk(wr_clk), .srst(wr_srst), .d(rgray), .q(rgray_ws));
  dcf_gray_sync #(.W(PW)) u_w2r (.clk(rd_clk), .srst(rd_srst), .d(wgray), .q(wgray_rs));

  dcf_wr_side #(.ADDR_W(ADDR_W), .AF_OFFSET(AF_OFFSET)) u_wr (
    .clk(wr_clk), .srst(wr_srst), .wr_en(wr_en), .rq_gray(rgray_ws),
    .full(full), .afull(almost_full), .wr_err(wr_err),
    .wgray(wgray), .waddr(waddr), .wr_go(wr_go)
  );

  dcf_rd_side #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .AE_OFFSET(AE_OFFSET)) u_rd (
    .clk(rd_clk), .srst(rd_srst), .rd_en(rd_en), .wq_gray(wgray_rs),
    .mem_q(mem_q), .empty(empty), .aempty(almost_empty), .rd_err(rd_err),
    .rgray(rgray), .raddr(raddr), .rd_data(rd_data)
  );

  // storage: written on the write clock, read address from the read side
  always_ff @(posedge wr_clk) begin
    if (wr_go) store[waddr] <= wr_data;
  end

  assign mem_q = store[raddr];
endmodule

// File: tb/dual_clock_fifo_test.sv
`timescale 1ns/1ps
module dual_clock_fifo_test;
  localparam int DW = 8, AW = 4, AF = 2, AE = 2, DEPTH = 1 << AW, STREAM = 200;

  logic rst = 1'b0, wr_clk = 1'b0, rd_clk = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_data;
  logic full, almost_full, wr_err, empty, almost_empty, rd_err;

  int tests = 0, fails = 0;
  logic [DW-1:0] sb[$];

  dual_clock_fifo #(.DATA_W(DW), .ADDR_W(AW), .AF_OFFSET(AF), .AE_OFFSET(AE)) uut (
    .rst(rst), .wr_clk(wr_clk), .wr_en(wr_en), .wr_data(wr_data), .full(full),
    .almost_full(almost_full), .wr_err(wr_err), .rd_clk(rd_clk), .rd_en(rd_en),
    .rd_data(rd_data), .empty(empty), .almost_empty(almost_empty), .rd_err(rd_err)
  );

  always #2.5 wr_clk = ~wr_clk;   // 200 MHz write clock
  always #3.5 rd_clk = ~rd_clk;   // unrelated read clock

  task automatic check_eq(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // monitor side: compare a delivered word against the scoreboard
  task automatic score_word();
    if (sb.size() == 0) check_eq("R3 word delivered with none expected", int'(rd_data), -1);
    else check_eq("R2 order", int'(rd_data), int'(sb.pop_front()));
  endtask

  // driver: one write cycle, expected item pushed only if accepted
  task automatic push_word(input logic [DW-1:0] d);
    @(negedge wr_clk);
    wr_en = 1'b1;
    wr_data = d;
    if (!full) sb.push_back(d);
    @(negedge wr_clk);
    wr_en = 1'b0;
  endtask

  task automatic pull_word(output logic acc);
    @(negedge rd_clk);
    acc = !empty;
    rd_en = 1'b1;
    @(negedge rd_clk);
    rd_en = 1'b0;
    if (acc) score_word();
  endtask

  task automatic reset_flags(input string tag);
    check_eq({tag, " full"}, int'(full), 0);
    check_eq({tag, " almost_full"}, int'(almost_full), 0);
    check_eq({tag, " wr_err"}, int'(wr_err), 0);
    check_eq({tag, " empty"}, int'(empty), 1);
    check_eq({tag, " almost_empty"}, int'(almost_empty), 1);
    check_eq({tag, " rd_err"}, int'(rd_err), 0);
  endtask

  initial begin
    repeat (150000) @(posedge wr_clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic acc;
    int rem;
    #1 rst = 1'b1;
    repeat (6) @(negedge wr_clk);
    reset_flags("R1 during reset");
    rst = 1'b0;
    repeat (6) @(negedge wr_clk);
    reset_flags("R1 after release");
    check_eq("R1 rd_data", int'(rd_data), 0);

    // R6 / R5: read held on an empty buffer
    @(negedge rd_clk);
    rd_en = 1'b1;
    for (int k = 0; k < 3; k++) begin
      @(negedge rd_clk);
      check_eq("R6 rd_err held", int'(rd_err), 1);
      check_eq("R5 rd_data held", int'(rd_data), 0);
      check_eq("R9 still empty", int'(empty), 1);
    end
    rd_en = 1'b0;
    @(negedge rd_clk);
    check_eq("R6 rd_err drops", int'(rd_err), 0);

    // R7 / R8: fill with no reads
    for (int i = 0; i < DEPTH; i++) begin
      push_word(DW'(8'hA0 + i));
      check_eq("R7 full level", int'(full), int'(i + 1 == DEPTH));
      check_eq("R8 almost_full level", int'(almost_full), int'(i + 1 >= DEPTH - AF));
      check_eq("R4 no wr_err", int'(wr_err), 0);
    end

    // R3 / R4: writes while full
    for (int k = 0; k < 2; k++) begin
      push_word(8'hEE);
      check_eq("R4 wr_err on full", int'(wr_err), 1);
      check_eq("R3 still full", int'(full), 1);
    end
    @(negedge wr_clk);
    check_eq("R4 wr_err clears", int'(wr_err), 0);

    repeat (12) @(negedge rd_clk);
    check_eq("R9 not empty", int'(empty), 0);
    check_eq("R10 not almost_empty", int'(almost_empty), 0);

    // drain: R2 order, R9 / R10 levels
    rem = DEPTH;
    for (int i = 0; i < DEPTH; i++) begin
      pull_word(acc);
      rem--;
      check_eq("R9 read accepted", int'(acc), 1);
      check_eq("R9 empty level", int'(empty), int'(rem == 0));
      check_eq("R10 almost_empty level", int'(almost_empty), int'(rem <= AE));
      check_eq("R6 no rd_err", int'(rd_err), 0);
    end
    pull_word(acc);
    check_eq("R9 refused when empty", int'(acc), 0);
    check_eq("R6 rd_err on empty", int'(rd_err), 1);
    check_eq("R5 last word kept", int'(rd_data), 8'hAF);
    check_eq("R3 nothing left", sb.size(), 0);

    repeat (12) @(negedge wr_clk);
    check_eq("R7 full clears", int'(full), 0);
    check_eq("R8 almost_full clears", int'(almost_full), 0);

    // R2: concurrent streaming, read clock slower than write clock
    fork
      begin : writer
        int sent, cyc;
        sent = 0;
        cyc = 0;
        while (sent < STREAM) begin
          @(negedge wr_clk);
          cyc++;
          if (cyc % 4 != 3) begin
            wr_data = DW'(sent * 7 + 3);
            wr_en = 1'b1;
            if (!full) begin
              sb.push_back(wr_data);
              sent++;
            end
          end else wr_en = 1'b0;
        end
        @(negedge wr_clk);
        wr_en = 1'b0;
      end
      begin : reader
        int got, cyc;
        logic pend, err_exp;
        got = 0;
        cyc = 0;
        pend = 1'b0;
        err_exp = 1'b0;
        while (got < STREAM) begin
          @(negedge rd_clk);
          check_eq("R6 rd_err stream", int'(rd_err), int'(err_exp));
          if (pend) begin
            score_word();
            got++;
          end
          cyc++;
          rd_en = (got < STREAM) && (cyc % 5 != 2);
          pend = rd_en && !empty;
          err_exp = rd_en && empty;
        end
        rd_en = 1'b0;
      end
    join
    check_eq("R2 stream fully consumed", sb.size(), 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule